// File: doc/BRIEF.md
# Write-Channel Protocol Compliance Monitor

This block sits beside a host-memory write request channel and watches it without touching it. On every cycle in which the channel's valid signal is high it takes one 80-bit request header. It classifies the header by request type, follows the framing of multi-line write bursts from beat to beat, and checks each header against the legality rules. The rules for the header that opens a burst differ from the rules for the headers that follow it.

Every kind of violation has its own sticky flag. A code register holds the earliest violation seen. Both stay set until the clear input is pulsed. The monitor has no effect on traffic or data payloads. It is meant to be instantiated next to a request source in simulation or in silicon, and its flags are read as a health indication for that source.

Header layout (bit positions are fixed because the downstream decoder uses them): [79:74] byte count, [73:72] channel select, [71] start-of-burst, [70] byte mode, [69:68] length code, [67:64] request type, [63:58] first byte index, [57:16] line address, [15:0] tag. Error code N means flag bit N-1. Code 0 means no error.

Top module: `wrmon_top`

## Requirements
- R1: `req_kind` decodes header bits [67:64] without a clock: types 0, 1 and 2 give 0 (memory write), 4 gives 1 (fence), 6 gives 2 (interrupt), and every other type gives 3 (reserved).
- R2: A valid write header with bit 71 set opens a burst. Length code 0 gives 1 beat, code 1 gives 2 beats and code 3 gives 4 beats. `burst_open` stays high while later beats are still owed. Length code 2 sets flag bit 0 (code 1) and is treated as a single beat.
- R3: An opening header with length code 1 and address bit 16 set, or with length code 3 and address bits [17:16] not zero, sets flag bit 1 (code 2).
- R4: An opening header in byte mode (bit 70 = 1) with a nonzero length code sets flag bit 2 (code 3). An opening header in line mode with a nonzero byte index or byte count sets flag bit 3 (code 4).
- R5: An opening header in byte mode with a byte count of 0 sets flag bit 4 (code 5).
- R6: A later beat with byte mode set, or with a nonzero byte index or byte count, sets flag bit 5 (code 6).
- R7: The address bits [17:16] of a later beat must equal those of the opening beat plus the beat's position in the burst, modulo 4. Any other value sets flag bit 6 (code 7).
- R8: A fence or interrupt while a burst is open sets flag bit 7 (code 8) and leaves the burst state unchanged. When no burst is open, a fence or interrupt is not checked for framing.
- R9: A reserved request type sets flag bit 8 (code 9). Such a header is still framed as a write.
- R10: An opening header that arrives while beats are still owed sets flag bit 9 (code 10), and the new burst then replaces the old one.
- R11: A write header with bit 71 clear that arrives while no burst is open sets flag bit 10 (code 11).
- R12: Flags are sticky. `first_err` holds the code of the first violation, and the lowest code wins when several occur in one cycle. A cycle with `clr` high replaces the flags with that cycle's violations and reloads `first_err` from those violations alone.
- R13: A header presented while `hdr_valid` is low changes no flag and no burst state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and first-error code |
| hdr_valid | input | 1 | Header on `hdr` is a request this cycle |
| hdr | input | 80 | Request header |
| req_kind | output | 2 | Request class of the current header |
| burst_open | output | 1 | Later beats of a burst are still owed |
| err_flags | output | 11 | Sticky violation flags |
| first_err | output | 4 | Code of the earliest violation, 0 if none |

## Verification
The bench checks the address order at the third beat of a four-line burst. A design that counts from zero instead of from the opening address, or that stops advancing after a bad beat, flags the wrong beat. It places a fence in the middle of a burst. A design that lets control headers consume a beat would then report an orphan on the real final beat. It opens a new burst over an unfinished one and presents an orphan-shaped header while valid is low. These expose tracking that does not restart on truncation, or that acts on headers that are not valid. It also raises several violations in one cycle and combines a clear with a violation. A wrong priority or a clear that swallows the new error then shows up in `first_err`.

// File: rtl/wrmon_pkg.sv
package wrmon_pkg;
  localparam int HDR_W     = 80;
  localparam int ADDR_W    = 42;
  localparam int BYTE_W    = 6;
  localparam int TAG_W     = 16;
  localparam int TYPE_W    = 4;
  localparam int MAX_BEATS = 4;
  localparam int LEFT_W    = $clog2(MAX_BEATS);
  localparam int LO_W      = $clog2(MAX_BEATS);
  localparam int NERR      = 11;
  localparam int CODE_W    = $clog2(NERR + 1);

  // flag bit indices; code = index + 1, lower code has priority
  localparam int EB_LEN    = 0;
  localparam int EB_ALIGN  = 1;
  localparam int EB_MODELN = 2;
  localparam int EB_LINEBY = 3;
  localparam int EB_ZEROBY = 4;
  localparam int EB_LATER  = 5;
  localparam int EB_ORDER  = 6;
  localparam int EB_CTRL   = 7;
  localparam int EB_RSVD   = 8;
  localparam int EB_TRUNC  = 9;
  localparam int EB_ORPHAN = 10;

  localparam logic [TYPE_W-1:0] T_FENCE = 4'h4;
  localparam logic [TYPE_W-1:0] T_INTR  = 4'h6;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_FENCE = 2'd1,
    KIND_INTR  = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef struct packed {
    logic [BYTE_W-1:0] blen;
    logic [1:0]        vc;
    logic              sop;
    logic              mode;
    logic [1:0]        len;
    logic [TYPE_W-1:0] rtype;
    logic [BYTE_W-1:0] bstart;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } hdr_t;

  function automatic kind_e classify(input logic [TYPE_W-1:0] t);
    if (t <= 4'h2)        return KIND_WRITE;
    else if (t == T_FENCE) return KIND_FENCE;
    else if (t == T_INTR)  return KIND_INTR;
    else                   return KIND_RSVD;
  endfunction

  function automatic int unsigned beats_of(input logic [1:0] code);
    case (code)
      2'd1:    return 2;
      2'd3:    return MAX_BEATS;
      default: return 1;
    endcase
  endfunction

  function automatic logic is_aligned(input logic [1:0] code,
                                      input logic [LO_W-1:0] lo);
    case (code)
      2'd1:    return lo[0] == 1'b0;
      2'd3:    return lo == '0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] lowest_code(input logic [NERR-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NERR - 1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/wrmon_decode.sv
module wrmon_decode
  import wrmon_pkg::*;
(
  input  logic [TYPE_W-1:0] rtype,
  output kind_e             kind,
  output logic              is_ctrl,
  output logic              is_rsvd
);
  always_comb begin
    kind = classify(rtype);
  end

  assign is_ctrl = (kind == KIND_FENCE) || (kind == KIND_INTR);
  assign is_rsvd = (kind == KIND_RSVD);
endmodule

// File: rtl/wrmon_rules.sv
module wrmon_rules
  import wrmon_pkg::*;
(
  input  logic              opening,
  input  logic              mode,
  input  logic [1:0]        len,
  input  logic [LO_W-1:0]   lo,
  input  logic [BYTE_W-1:0] bstart,
  input  logic [BYTE_W-1:0] blen,
  output logic              bad_len,
  output logic              misalign,
  output logic              mode_len,
  output logic              line_bytes,
  output logic              zero_bytes
);
  logic bytes_used;
  assign bytes_used = (bstart != '0) || (blen != '0);

  assign bad_len    = opening && (len == 2'd2);
  assign misalign   = opening && !is_aligned(len, lo);
  assign mode_len   = opening && mode && (len != 2'd0);
  assign line_bytes = opening && !mode && bytes_used;
  assign zero_bytes = opening && mode && (blen == '0);
endmodule

// File: rtl/wrmon_burst.sv
module wrmon_burst
  import wrmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic              is_ctrl,
  input  logic              sop,
  input  logic              mode,
  input  logic [1:0]        len,
  input  logic [LO_W-1:0]   lo,
  input  logic [BYTE_W-1:0] bstart,
  input  logic [BYTE_W-1:0] blen,
  output logic              opening,
  output logic              burst_open,
  output logic              hit_trunc,
  output logic              hit_orphan,
  output logic              hit_later,
  output logic              hit_order,
  output logic              hit_ctrl
);
  logic [LEFT_W-1:0] left_q;
  logic [LO_W-1:0]   next_lo_q;
  logic              framed;
  logic              cont;

  assign burst_open = (left_q != '0);
  assign framed     = hdr_valid && !is_ctrl;
  assign opening    = framed && sop;
  assign cont       = framed && !sop && burst_open;

  assign hit_trunc  = opening && burst_open;
  assign hit_orphan = framed && !sop && !burst_open;
  assign hit_later  = cont && (mode || (bstart != '0) || (blen != '0));
  assign hit_order  = cont && (lo != next_lo_q);
  assign hit_ctrl   = hdr_valid && is_ctrl && burst_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      next_lo_q <= '0;
    end else if (opening) begin
      left_q    <= LEFT_W'(beats_of(len) - 1);
      next_lo_q <= lo + 1'b1;
    end else if (cont) begin
      left_q    <= left_q - 1'b1;
      next_lo_q <= next_lo_q + 1'b1;
    end
  end

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(left_q) && $stable(next_lo_q)));

  // R2
  quad_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opening && len == 2'd3) |=> (left_q == LEFT_W'(MAX_BEATS - 1)));

  // R10
  trunc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_trunc && len == 2'd0) |=> !burst_open);
endmodule

// File: rtl/wrmon_log.sv
module wrmon_log
  import wrmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NERR-1:0]   hit,
  output logic [NERR-1:0]   flags_q,
  output logic [CODE_W-1:0] first_q
);
  logic [NERR-1:0] flags_d;
  logic [NERR-1:0] first_mask;

  for (genvar i = 0; i < NERR; i++) begin : g_flag
    assign flags_d[i] = clr ? hit[i] : (flags_q[i] | hit[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      first_q <= '0;
    end else begin
      flags_q <= flags_d;
      if (clr || first_q == '0) first_q <= lowest_code(hit);
    end
  end

  assign first_mask = (first_q == '0) ? '0
                    : (NERR'(1) << (first_q - CODE_W'(1)));

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R12
  first_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((first_q != '0) == (flags_q != '0)));

  // R12
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q != '0) |-> ((first_mask & flags_q) == first_mask));
endmodule

// File: rtl/wrmon_top.sv
module wrmon_top
  import wrmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 hdr_valid,
  input  logic [HDR_W-1:0]     hdr,
  output logic [1:0]           req_kind,
  output logic                 burst_open,
  output logic [NERR-1:0]      err_flags,
  output logic [CODE_W-1:0]    first_err
);
  hdr_t            h;
  kind_e           kind;
  logic            is_ctrl;
  logic            is_rsvd;
  logic            opening;
  logic            bad_len, misalign, mode_len, line_bytes, zero_bytes;
  logic            hit_trunc, hit_orphan, hit_later, hit_order, hit_ctrl;
  logic [NERR-1:0] hit;
  logic            unused_fields;

  assign h             = hdr;
  assign unused_fields = ^{h.vc, h.tag, h.addr[ADDR_W-1:LO_W]};

  wrmon_decode u_decode (
    .rtype   (h.rtype),
    .kind    (kind),
    .is_ctrl (is_ctrl),
    .is_rsvd (is_rsvd)
  );

  wrmon_burst u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_valid  (hdr_valid),
    .is_ctrl    (is_ctrl),
    .sop        (h.sop),
    .mode       (h.mode),
    .len        (h.len),
    .lo         (h.addr[LO_W-1:0]),
    .bstart     (h.bstart),
    .blen       (h.blen),
    .opening    (opening),
    .burst_open (burst_open),
    .hit_trunc  (hit_trunc),
    .hit_orphan (hit_orphan),
    .hit_later  (hit_later),
    .hit_order  (hit_order),
    .hit_ctrl   (hit_ctrl)
  );

  wrmon_rules u_rules (
    .opening    (opening),
    .mode       (h.mode),
    .len        (h.len),
    .lo         (h.addr[LO_W-1:0]),
    .bstart     (h.bstart),
    .blen       (h.blen),
    .bad_len    (bad_len),
    .misalign   (misalign),
    .mode_len   (mode_len),
    .line_bytes (line_bytes),
    .zero_bytes (zero_bytes)
  );

  always_comb begin
    hit            = '0;
    hit[EB_LEN]    = bad_len;
    hit[EB_ALIGN]  = misalign;
    hit[EB_MODELN] = mode_len;
    hit[EB_LINEBY] = line_bytes;
    hit[EB_ZEROBY] = zero_bytes;
    hit[EB_LATER]  = hit_later;
    hit[EB_ORDER]  = hit_order;
    hit[EB_CTRL]   = hit_ctrl;
    hit[EB_RSVD]   = hdr_valid && is_rsvd;
    hit[EB_TRUNC]  = hit_trunc;
    hit[EB_ORPHAN] = hit_orphan;
  end

  wrmon_log u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .hit     (hit),
    .flags_q (err_flags),
    .first_q (first_err)
  );

  assign req_kind = kind;

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_valid && !clr) |=> $stable(err_flags));

  // R8
  ctrl_keeps_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && is_ctrl) |=> $stable(burst_open));
endmodule

// File: tb/tb_wrmon_top.sv
`timescale 1ns/1ps
module tb_wrmon_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [79:0] hdr = '0;
  logic [1:0]  req_kind;
  logic        burst_open;
  logic [10:0] err_flags;
  logic [3:0]  first_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_flags = 0;
  int m_first = 0;
  int owed[$];

  always #2.5 clk = ~clk;

  wrmon_top dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hdr_valid(hdr_valid), .hdr(hdr),
    .req_kind(req_kind), .burst_open(burst_open),
    .err_flags(err_flags), .first_err(first_err)
  );

  function automatic string tag_of(int b);
    case (b)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R7";  7: return "R8";
      8: return "R9";  9: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic int exp_kind(int t);
    if (t <= 2) return 0;
    if (t == 4) return 1;
    if (t == 6) return 2;
    return 3;
  endfunction

  function automatic logic [79:0] mk(int blen, int sop, int mode, int len,
                                     int typ, int bst, int lo);
    logic [41:0] a;
    a = 42'h1c0 + 42'(lo);
    return {6'(blen), 2'd1, 1'(sop), 1'(mode), 2'(len), 4'(typ), 6'(bst), a, 16'h5a5a};
  endfunction

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // behavioural model, one step per rising edge
  always @(posedge clk) begin : model
    int hit, code, blen, sop, mode, len, typ, bst, lo;
    if (!rst_n) begin
      m_flags = 0; m_first = 0; owed.delete();
    end else begin
      hit = 0;
      blen = int'(hdr[79:74]); sop = int'(hdr[71]); mode = int'(hdr[70]);
      len = int'(hdr[69:68]); typ = int'(hdr[67:64]); bst = int'(hdr[63:58]);
      lo = int'(hdr[17:16]);
      if (hdr_valid) begin
        if (typ == 4 || typ == 6) begin
          if (owed.size() > 0) hit |= 1 << 7;
        end else begin
          if (typ > 2) hit |= 1 << 8;
          if (sop) begin
            if (owed.size() > 0) hit |= 1 << 9;
            if (len == 2) hit |= 1 << 0;
            if ((len == 1 && lo % 2 != 0) || (len == 3 && lo != 0)) hit |= 1 << 1;
            if (mode && len != 0) hit |= 1 << 2;
            if (!mode && (bst != 0 || blen != 0)) hit |= 1 << 3;
            if (mode && blen == 0) hit |= 1 << 4;
            owed.delete();
            for (int k = 1; k < (len == 1 ? 2 : (len == 3 ? 4 : 1)); k++)
              owed.push_back((lo + k) % 4);
          end else if (owed.size() == 0) begin
            hit |= 1 << 10;
          end else begin
            if (mode || bst != 0 || blen != 0) hit |= 1 << 5;
            if (lo != owed[0]) hit |= 1 << 6;
            void'(owed.pop_front());
          end
        end
      end
      code = 0;
      for (int i = 10; i >= 0; i--) if ((hit >> i) & 1) code = i + 1;
      if (clr) begin
        m_flags = hit; m_first = code;
      end else begin
        m_flags |= hit;
        if (m_first == 0) m_first = code;
      end
    end
  end

  task automatic compare();
    for (int b = 0; b < 11; b++) check(tag_of(b), int'(err_flags[b]), (m_flags >> b) & 1);
    check("R12", int'(first_err), m_first);
    check("R2", int'(burst_open), int'(owed.size() > 0));
  endtask

  task automatic drive(logic [79:0] h, bit v, bit c);
    @(negedge clk);
    compare();
    hdr = h; hdr_valid = v; clr = c;
    #1;
    check("R1", int'(req_kind), exp_kind(int'(h[67:64])));
  endtask

  task automatic idle();
    drive('0, 1'b0, 1'b0);
  endtask

  task automatic wipe();
    drive('0, 1'b0, 1'b1);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R12", int'(err_flags), 0);
    check("R12", int'(first_err), 0);
    check("R2", int'(burst_open), 0);
    rst_n = 1'b1;
    idle();

    // R2 legal four-line burst
    drive(mk(0, 1, 0, 3, 0, 0, 0), 1, 0);
    idle();
    check("R2", int'(burst_open), 1);
    for (int k = 1; k < 4; k++) drive(mk(0, 0, 0, 0, 1, 0, k), 1, 0);
    idle();
    check("R2", int'(first_err), 0);
    check("R2", int'(burst_open), 0);

    // R3 misaligned two-line opener
    drive(mk(0, 1, 0, 1, 2, 0, 1), 1, 0);
    drive(mk(0, 0, 0, 0, 2, 0, 2), 1, 0);
    idle();
    check("R3", int'(first_err), 2);
    wipe();
    check("R12", int'(first_err), 0);

    // R2 illegal length code
    drive(mk(0, 1, 0, 2, 0, 0, 0), 1, 0);
    idle();
    check("R2", int'(first_err), 1);
    check("R2", int'(burst_open), 0);
    wipe();

    // R4 byte mode with length code
    drive(mk(5, 1, 1, 1, 0, 0, 0), 1, 0);
    drive(mk(0, 0, 0, 0, 0, 0, 1), 1, 0);
    idle();
    check("R4", int'(first_err), 3);
    wipe();

    // R4 line mode with byte index
    drive(mk(0, 1, 0, 0, 0, 5, 0), 1, 0);
    idle();
    check("R4", int'(first_err), 4);
    wipe();

    // R5 byte mode, zero count
    drive(mk(0, 1, 1, 0, 0, 7, 0), 1, 0);
    idle();
    check("R5", int'(first_err), 5);
    wipe();

    // R6 later beat carrying byte index
    drive(mk(0, 1, 0, 1, 0, 0, 0), 1, 0);
    drive(mk(0, 0, 0, 0, 0, 3, 1), 1, 0);
    idle();
    check("R6", int'(first_err), 6);
    wipe();

    // R7 address order break at third beat
    drive(mk(0, 1, 0, 3, 0, 0, 0), 1, 0);
    drive(mk(0, 0, 0, 0, 0, 0, 1), 1, 0);
    drive(mk(0, 0, 0, 0, 0, 0, 3), 1, 0);
    idle();
    check("R7", int'(first_err), 7);
    drive(mk(0, 0, 0, 0, 0, 0, 3), 1, 0);
    idle();
    check("R7", int'(err_flags), 11'h040);
    wipe();

    // R8 fence mid-burst, then idle fence and interrupt
    drive(mk(0, 1, 0, 1, 0, 0, 0), 1, 0);
    drive(mk(0, 0, 0, 0, 4, 0, 0), 1, 0);
    idle();
    check("R8", int'(first_err), 8);
    check("R8", int'(burst_open), 1);
    drive(mk(0, 0, 0, 0, 0, 0, 1), 1, 0);
    drive(mk(0, 0, 0, 0, 6, 0, 0), 1, 0);
    idle();
    check("R8", int'(err_flags), 11'h080);
    wipe();

    // R9 reserved type framed as a write
    drive(mk(0, 1, 0, 0, 5, 0, 0), 1, 0);
    idle();
    check("R9", int'(first_err), 9);
    check("R9", int'(err_flags), 11'h100);
    wipe();

    // R10 truncated burst
    drive(mk(0, 1, 0, 3, 0, 0, 0), 1, 0);
    drive(mk(0, 1, 0, 0, 0, 0, 0), 1, 0);
    idle();
    check("R10", int'(first_err), 10);
    check("R10", int'(burst_open), 0);
    wipe();

    // R11 orphan beat
    drive(mk(0, 0, 0, 0, 0, 0, 0), 1, 0);
    idle();
    check("R11", int'(first_err), 11);
    wipe();

    // R12 same-cycle priority
    drive(mk(0, 1, 1, 1, 0, 0, 0), 1, 0);
    drive(mk(0, 0, 0, 0, 0, 0, 1), 1, 0);
    idle();
    check("R12", int'(first_err), 3);
    check("R12", int'(err_flags), 11'h014);
    // R12 sticky: a later error keeps the first code
    drive(mk(0, 0, 0, 0, 0, 0, 0), 1, 0);
    idle();
    check("R12", int'(first_err), 3);
    check("R12", int'(err_flags), 11'h414);
    // R12 clear together with a violation
    drive(mk(0, 0, 0, 0, 0, 0, 0), 1, 1);
    idle();
    check("R12", int'(first_err), 11);
    check("R12", int'(err_flags), 11'h400);
    wipe();

    // R13 invalid header has no effect
    drive(mk(0, 0, 1, 2, 9, 3, 1), 0, 0);
    idle();
    check("R13", int'(err_flags), 0);
    check("R13", int'(burst_open), 0);

    // mixed traffic compared each cycle
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6) begin
        int len, lo, typ;
        len = ($urandom_range(0, 2) == 0) ? 0 : (($urandom_range(0, 1) == 0) ? 1 : 3);
        lo  = (len == 0) ? $urandom_range(0, 3) : ((len == 1) ? 2 * $urandom_range(0, 1) : 0);
        typ = $urandom_range(0, 2);
        if (len == 0 && $urandom_range(0, 1) == 1)
          drive(mk($urandom_range(1, 63), 1, 1, 0, typ, $urandom_range(0, 63), lo), 1, 0);
        else
          drive(mk(0, 1, 0, len, typ, 0, lo), 1, 0);
        for (int k = 1; k < (len == 1 ? 2 : (len == 3 ? 4 : 1)); k++) begin
          if ($urandom_range(0, 3) == 0) idle();
          drive(mk(0, 0, 0, 0, typ, 0, (lo + k) % 4), 1, 0);
        end
      end else if (sel < 9) begin
        drive({$urandom, $urandom, 16'($urandom)}, 1'($urandom_range(0, 1)), 1'b0);
      end else begin
        drive({$urandom, $urandom, 16'($urandom)}, 1'($urandom_range(0, 1)), 1'b1);
      end
    end
    idle();
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule